// File: doc/BRIEF.md
# Miss-Tracking Entry Queue

This block keeps a small pool of entries that follow outstanding cache misses. Each entry is opened with a block address, an absolute ready time (in cycles of an internal time base), an order stamp taken from a running counter, and a count of waiting targets. An entry is *pending* while it is allocated and not in service, meaning its request has not yet gone downstream. The queue offers one head entry to the downstream sender. It prefers an entry that was explicitly moved to the front. If there is none, it offers the ready entry with the earliest ready time, and the older order stamp wins a tie.

The surrounding cache issues one command per clock: allocate, free, move-to-front, delay, mark-in-service, resend, or pop one target. The queue reports its occupancy, whether anything is pending, whether it is full, and whether a prefetch may still claim an entry. The prefetch limit holds back the overflow entries, one more entry, and the entries kept for later demand misses.

Top module: `miss_queue`

## Requirements
- R1: After a synchronous reset every entry is free: `used_o`=0, `pending_o`=0, `head_valid_o`=0, `full_o`=0, `err_o`=0, `alloc_ok_o`=0, `pop_freed_o`=0, and `prefetch_ok_o`=1 whenever the prefetch limit is positive.
- R2: An accepted allocate takes the lowest-numbered free entry. It stores the address, the ready time (`cmd_time`), the next order stamp and the target count (0 is taken as 1), and it increments `used_o`. In the following cycle it pulses `alloc_ok_o` for one cycle with `alloc_idx_o` set to the entry number. `head_addr_o` returns the stored address of the head entry.
- R3: `full_o` is 1 exactly when `used_o` ≥ N_ENTRIES − OVF_RESERVE. An allocate while full changes nothing and pulses `err_o` for one cycle.
- R4: `prefetch_ok_o` is 1 exactly when `used_o` < N_ENTRIES − (OVF_RESERVE + 1 + DEMAND_RESERVE).
- R5: `pending_o` is 1 exactly when at least one allocated entry is not in service.
- R6: An entry is ready when its ready time ≤ the time base. The time base is 0 after reset and then counts up by one per clock, saturating at its maximum. The head is the pending entry carrying the front mark if there is one. Otherwise it is the ready pending entry with the smallest ready time, and the smaller order stamp wins a tie. `head_valid_o` is 0 when no entry qualifies.
- R7: Move-to-front on an allocated entry that is not in service gives that entry the single front mark. On an entry that is in service or free it has no effect.
- R8: Delay adds `cmd_time` to an allocated entry's ready time and clears its front mark, so any entry that is now ready earlier comes ahead of it.
- R9: Mark-in-service removes a pending entry from the pending set and clears its front mark. Resend returns an in-service entry to the pending set.
- R10: Pop-target on an allocated entry that holds more than one target decrements its count. If the entry holds one target or fewer, the entry is freed, `used_o` drops by one, and `pop_freed_o` pulses for one cycle.
- R11: Free clears an allocated entry's valid, in-service and front state and decrements `used_o` in the same clock. Free on an unallocated entry has no effect.
- R12: A command is taken only when `cmd_valid`=1, and at most one command is taken per clock. `cmd_op` encodings: 0 none, 1 allocate, 2 free, 3 move-to-front, 4 delay, 5 mark-in-service, 6 resend, 7 pop-target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_idx | input | IDX_W | Target entry for non-allocate commands |
| cmd_addr | input | ADDR_W | Block address for allocate |
| cmd_time | input | TIME_W | Ready time (allocate) or added cycles (delay) |
| cmd_tgts | input | TGT_W | Initial target count for allocate |
| alloc_idx_o | output | IDX_W | Entry taken by the last accepted allocate |
| alloc_ok_o | output | 1 | One-cycle pulse after an accepted allocate |
| err_o | output | 1 | One-cycle pulse after an allocate refused while full |
| pop_freed_o | output | 1 | One-cycle pulse after a pop that freed its entry |
| used_o | output | CNT_W | Number of allocated entries |
| pending_o | output | 1 | Some allocated entry is not in service |
| prefetch_ok_o | output | 1 | A prefetch may allocate |
| full_o | output | 1 | Allocation limit reached |
| head_valid_o | output | 1 | A head entry is offered |
| head_idx_o | output | IDX_W | Head entry number |
| head_addr_o | output | ADDR_W | Block address of the head entry |

## Verification
The head selection is driven with ready times given out of allocation order, so time-order and stamp-order choices give different heads. Delays are chosen to land on an exact tie, which exercises the stamp tie-break, and then to push an entry past a rival, which exercises the reorder. Move-to-front is sent both to a pending entry and to one in service, to tell a taken mark from an ignored one. A pending entry whose ready time lies far in the future shows that `pending_o` and `head_valid_o` are separate. A fill to the limit steps across both occupancy thresholds and then tries one allocate too many.

// File: rtl/miss_queue_pkg.sv
package miss_queue_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_FREE   = 3'd2,
    OP_FRONT  = 3'd3,
    OP_DELAY  = 3'd4,
    OP_SERVE  = 3'd5,
    OP_RESEND = 3'd6,
    OP_POP    = 3'd7
  } mq_op_e;
endpackage

// File: rtl/miss_queue_freefind.sv
// Finds the lowest-numbered free entry.
module miss_queue_freefind #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  valid,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/miss_queue_pick.sv
// Chooses the head: the front-marked entry first, otherwise the ready entry
// with the smallest {ready time, order stamp} key.
module miss_queue_pick #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int TW = 16,
  parameter int SW = 8
) (
  input  logic [N-1:0]         elig,
  input  logic [N-1:0]         front,
  input  logic [N-1:0][TW-1:0] rdy,
  input  logic [N-1:0][SW-1:0] stp,
  output logic                 head_v,
  output logic [IW-1:0]        head_idx
);
  localparam int KW = TW + SW;

  logic          have, fhit;
  logic [KW-1:0] bkey, key;
  logic [IW-1:0] best, fidx;

  always_comb begin
    have = 1'b0;
    fhit = 1'b0;
    bkey = '0;
    key  = '0;
    best = '0;
    fidx = '0;
    for (int i = 0; i < N; i++) begin
      key = {rdy[i], stp[i]};
      if (front[i] && !fhit) begin
        fhit = 1'b1;
        fidx = IW'(i);
      end
      if (elig[i] && (!have || key < bkey)) begin
        have = 1'b1;
        bkey = key;
        best = IW'(i);
      end
    end
    head_v   = fhit | have;
    head_idx = fhit ? fidx : best;
  end
endmodule

// File: rtl/miss_queue.sv
module miss_queue
  import miss_queue_pkg::*;
#(
  parameter int N_ENTRIES      = 8,
  parameter int OVF_RESERVE    = 1,
  parameter int DEMAND_RESERVE = 2,
  parameter int ADDR_W         = 16,
  parameter int TIME_W         = 16,
  parameter int TGT_W          = 3,
  parameter int STAMP_W        = 8,
  parameter int IDX_W          = $clog2(N_ENTRIES),
  parameter int CNT_W          = $clog2(N_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [TIME_W-1:0] cmd_time,
  input  logic [TGT_W-1:0]  cmd_tgts,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              alloc_ok_o,
  output logic              err_o,
  output logic              pop_freed_o,
  output logic [CNT_W-1:0]  used_o,
  output logic              pending_o,
  output logic              prefetch_ok_o,
  output logic              full_o,
  output logic              head_valid_o,
  output logic [IDX_W-1:0]  head_idx_o,
  output logic [ADDR_W-1:0] head_addr_o
);
  localparam int FULL_AT  = N_ENTRIES - OVF_RESERVE;
  localparam int PF_LIMIT = N_ENTRIES - (OVF_RESERVE + 1 + DEMAND_RESERVE);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL_AT);
  localparam logic [CNT_W-1:0] PF_C   = CNT_W'(PF_LIMIT > 0 ? PF_LIMIT : 0);

  // Per-entry state
  logic [N_ENTRIES-1:0]              valid_q, insvc_q, front_q;
  logic [N_ENTRIES-1:0][TIME_W-1:0]  ready_q;
  logic [N_ENTRIES-1:0][STAMP_W-1:0] stamp_q;
  logic [N_ENTRIES-1:0][TGT_W-1:0]   tgts_q;
  logic [ADDR_W-1:0]                 addr_mem [N_ENTRIES];

  logic [STAMP_W-1:0] stamp_ctr;
  logic [TIME_W-1:0]  now_q;
  logic [CNT_W-1:0]   used_q;

  mq_op_e               op;
  logic                 free_found, hit, alloc_go;
  logic [IDX_W-1:0]     free_idx;
  logic [N_ENTRIES-1:0] pend, ready_now, elig, front_pend;

  assign op       = mq_op_e'(cmd_op);
  assign hit      = valid_q[cmd_idx];
  assign alloc_go = cmd_valid && (op == OP_ALLOC) && !full_o && free_found;

  miss_queue_freefind #(.N(N_ENTRIES), .IW(IDX_W)) u_free (
    .valid (valid_q),
    .found (free_found),
    .idx   (free_idx)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_elig
    assign pend[g]       = valid_q[g] & ~insvc_q[g];
    assign ready_now[g]  = (ready_q[g] <= now_q);
    assign elig[g]       = pend[g] & ready_now[g];
    assign front_pend[g] = pend[g] & front_q[g];
  end

  miss_queue_pick #(.N(N_ENTRIES), .IW(IDX_W), .TW(TIME_W), .SW(STAMP_W)) u_pick (
    .elig     (elig),
    .front    (front_pend),
    .rdy      (ready_q),
    .stp      (stamp_q),
    .head_v   (head_valid_o),
    .head_idx (head_idx_o)
  );

  assign used_o        = used_q;
  assign pending_o     = |pend;
  assign full_o        = (used_q >= FULL_C);
  assign prefetch_ok_o = (PF_LIMIT > 0) && (used_q < PF_C);
  assign head_addr_o   = addr_mem[head_idx_o];

  // Address store: written only on allocate, no reset (RAM-friendly)
  always_ff @(posedge clk) begin
    if (alloc_go) addr_mem[free_idx] <= cmd_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      insvc_q     <= '0;
      front_q     <= '0;
      stamp_ctr   <= '0;
      now_q       <= '0;
      used_q      <= '0;
      err_o       <= 1'b0;
      alloc_ok_o  <= 1'b0;
      alloc_idx_o <= '0;
      pop_freed_o <= 1'b0;
    end else begin
      err_o       <= 1'b0;
      alloc_ok_o  <= 1'b0;
      pop_freed_o <= 1'b0;
      if (now_q != '1) now_q <= now_q + 1'b1;
      if (cmd_valid) begin
        unique case (op)
          OP_ALLOC: begin
            if (alloc_go) begin
              valid_q[free_idx] <= 1'b1;
              insvc_q[free_idx] <= 1'b0;
              front_q[free_idx] <= 1'b0;
              ready_q[free_idx] <= cmd_time;
              stamp_q[free_idx] <= stamp_ctr;
              tgts_q[free_idx]  <= (cmd_tgts == '0) ? TGT_W'(1) : cmd_tgts;
              stamp_ctr         <= stamp_ctr + 1'b1;
              used_q            <= used_q + 1'b1;
              alloc_idx_o       <= free_idx;
              alloc_ok_o        <= 1'b1;
            end else begin
              err_o <= 1'b1;
            end
          end
          OP_FREE: begin
            if (hit) begin
              valid_q[cmd_idx] <= 1'b0;
              insvc_q[cmd_idx] <= 1'b0;
              front_q[cmd_idx] <= 1'b0;
              used_q           <= used_q - 1'b1;
            end
          end
          OP_FRONT: begin
            if (hit && !insvc_q[cmd_idx]) begin
              front_q          <= '0;
              front_q[cmd_idx] <= 1'b1;
            end
          end
          OP_DELAY: begin
            if (hit) begin
              ready_q[cmd_idx] <= ready_q[cmd_idx] + cmd_time;
              front_q[cmd_idx] <= 1'b0;
            end
          end
          OP_SERVE: begin
            if (hit && !insvc_q[cmd_idx]) begin
              insvc_q[cmd_idx] <= 1'b1;
              front_q[cmd_idx] <= 1'b0;
            end
          end
          OP_RESEND: begin
            if (hit && insvc_q[cmd_idx]) insvc_q[cmd_idx] <= 1'b0;
          end
          OP_POP: begin
            if (hit) begin
              if (tgts_q[cmd_idx] <= TGT_W'(1)) begin
                valid_q[cmd_idx] <= 1'b0;
                insvc_q[cmd_idx] <= 1'b0;
                front_q[cmd_idx] <= 1'b0;
                used_q           <= used_q - 1'b1;
                pop_freed_o      <= 1'b1;
              end else begin
                tgts_q[cmd_idx] <= tgts_q[cmd_idx] - 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/miss_queue_chk.sv
module miss_queue_chk
  import miss_queue_pkg::*;
#(
  parameter int N_ENTRIES   = 8,
  parameter int OVF_RESERVE = 1,
  parameter int CNT_W       = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             alloc_ok_o,
  input logic             err_o,
  input logic             pop_freed_o,
  input logic [CNT_W-1:0] used_o,
  input logic             pending_o,
  input logic             prefetch_ok_o,
  input logic             full_o,
  input logic             head_valid_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(N_ENTRIES - OVF_RESERVE);

  p_refuse_full_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ALLOC && full_o) |=> (err_o && $stable(used_o)));

  p_err_cause_r3: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(cmd_valid && cmd_op == OP_ALLOC && full_o));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    used_o <= CAP);

  p_prefetch_below_full_r4: assert property (@(posedge clk) disable iff (rst)
    prefetch_ok_o |-> !full_o);

  p_head_needs_pending_r5: assert property (@(posedge clk) disable iff (rst)
    head_valid_o |-> pending_o);

  p_alloc_counts_r2: assert property (@(posedge clk) disable iff (rst)
    alloc_ok_o |-> (used_o == $past(used_o) + 1'b1));

  p_pop_frees_r10: assert property (@(posedge clk) disable iff (rst)
    pop_freed_o |-> ((used_o + 1'b1) == $past(used_o)));
endmodule

bind miss_queue miss_queue_chk #(
  .N_ENTRIES   (N_ENTRIES),
  .OVF_RESERVE (OVF_RESERVE),
  .CNT_W       (CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .alloc_ok_o    (alloc_ok_o),
  .err_o         (err_o),
  .pop_freed_o   (pop_freed_o),
  .used_o        (used_o),
  .pending_o     (pending_o),
  .prefetch_ok_o (prefetch_ok_o),
  .full_o        (full_o),
  .head_valid_o  (head_valid_o)
);

// File: tb/sim_miss_queue.sv
`timescale 1ns/1ps
module sim_miss_queue;
  localparam int IW = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [IW-1:0] cmd_idx = '0;
  logic [15:0]   cmd_addr = '0;
  logic [15:0]   cmd_time = '0;
  logic [2:0]    cmd_tgts = '0;
  logic [IW-1:0] alloc_idx_o, head_idx_o;
  logic          alloc_ok_o, err_o, pop_freed_o, pending_o, prefetch_ok_o;
  logic          full_o, head_valid_o;
  logic [CW-1:0] used_o;
  logic [15:0]   head_addr_o;

  always #4 clk = ~clk;

  miss_queue u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_addr(cmd_addr), .cmd_time(cmd_time),
    .cmd_tgts(cmd_tgts), .alloc_idx_o(alloc_idx_o), .alloc_ok_o(alloc_ok_o),
    .err_o(err_o), .pop_freed_o(pop_freed_o), .used_o(used_o),
    .pending_o(pending_o), .prefetch_ok_o(prefetch_ok_o), .full_o(full_o),
    .head_valid_o(head_valid_o), .head_idx_o(head_idx_o),
    .head_addr_o(head_addr_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [IW-1:0] idx,
                     input logic [15:0] tm, input logic [2:0] tg, input logic [15:0] ad);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
    cmd_time = tm; cmd_tgts = tg; cmd_addr = ad;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk_reset_state(input string tag);
    chk(used_o == 0,        tag, used_o, 0);
    chk(pending_o == 1'b0,  tag, pending_o, 0);
    chk(head_valid_o == 1'b0, tag, head_valid_o, 0);
    chk(full_o == 1'b0,     tag, full_o, 0);
    chk(prefetch_ok_o == 1'b1, tag, prefetch_ok_o, 1);
    chk(err_o == 1'b0 && alloc_ok_o == 1'b0 && pop_freed_o == 1'b0, tag,
        {err_o, alloc_ok_o, pop_freed_o}, 0);
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  idx;
    logic [15:0] tm;
    logic [2:0]  tg;
    logic [15:0] ad;
    logic [3:0]  e_used;
    logic        e_pend;
    logic        e_hv;
    logic [2:0]  e_hidx;
    logic        e_freed;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 3'd0, 16'd5,     3'd2, 16'h0100, 4'd1, 1'b1, 1'b1, 3'd0, 1'b0, 4'd2},  // R2 first entry
    '{3'd1, 3'd0, 16'd2,     3'd1, 16'h0200, 4'd2, 1'b1, 1'b1, 3'd1, 1'b0, 4'd6},  // R6 earlier ready wins
    '{3'd4, 3'd1, 16'd3,     3'd0, 16'h0000, 4'd2, 1'b1, 1'b1, 3'd0, 1'b0, 4'd8},  // R8 tie -> older stamp
    '{3'd4, 3'd0, 16'd1,     3'd0, 16'h0000, 4'd2, 1'b1, 1'b1, 3'd1, 1'b0, 4'd8},  // R8 delayed falls back
    '{3'd3, 3'd0, 16'd0,     3'd0, 16'h0000, 4'd2, 1'b1, 1'b1, 3'd0, 1'b0, 4'd7},  // R7 front taken
    '{3'd5, 3'd0, 16'd0,     3'd0, 16'h0000, 4'd2, 1'b1, 1'b1, 3'd1, 1'b0, 4'd9},  // R9 in service
    '{3'd3, 3'd0, 16'd0,     3'd0, 16'h0000, 4'd2, 1'b1, 1'b1, 3'd1, 1'b0, 4'd7},  // R7 ignored in service
    '{3'd5, 3'd1, 16'd0,     3'd0, 16'h0000, 4'd2, 1'b0, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 none pending
    '{3'd6, 3'd1, 16'd0,     3'd0, 16'h0000, 4'd2, 1'b1, 1'b1, 3'd1, 1'b0, 4'd9},  // R9 resend
    '{3'd7, 3'd1, 16'd0,     3'd0, 16'h0000, 4'd1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd10}, // R10 last target frees
    '{3'd7, 3'd0, 16'd0,     3'd0, 16'h0000, 4'd1, 1'b0, 1'b0, 3'd0, 1'b0, 4'd10}, // R10 count down only
    '{3'd6, 3'd0, 16'd0,     3'd0, 16'h0000, 4'd1, 1'b1, 1'b1, 3'd0, 1'b0, 4'd9},  // R9 resend
    '{3'd1, 3'd0, 16'hF000,  3'd1, 16'h0300, 4'd2, 1'b1, 1'b1, 3'd0, 1'b0, 4'd6},  // R6 future entry not head
    '{3'd2, 3'd0, 16'd0,     3'd0, 16'h0000, 4'd1, 1'b1, 1'b0, 3'd0, 1'b0, 4'd11}, // R11 pending but not ready
    '{3'd2, 3'd1, 16'd0,     3'd0, 16'h0000, 4'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd11}  // R11 empty again
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk_reset_state("R1 reset");

    // R12: strobe low means no command taken
    @(negedge clk);
    cmd_op = 3'd1; cmd_time = 16'd0; cmd_tgts = 3'd1;
    @(negedge clk);
    cmd_op = 3'd0;
    chk(used_o == 0, "R12 no strobe", used_o, 0);

    repeat (10) @(negedge clk);  // time base well past the small ready times
    for (int v = 0; v < NV; v++) begin
      cmd(VEC[v].op, VEC[v].idx, VEC[v].tm, VEC[v].tg, VEC[v].ad);
      chk(used_o == VEC[v].e_used, $sformatf("R%0d vec%0d used", VEC[v].rq, v),
          used_o, VEC[v].e_used);
      chk(pending_o == VEC[v].e_pend, $sformatf("R%0d vec%0d pending", VEC[v].rq, v),
          pending_o, VEC[v].e_pend);
      chk(head_valid_o == VEC[v].e_hv, $sformatf("R%0d vec%0d head_valid", VEC[v].rq, v),
          head_valid_o, VEC[v].e_hv);
      if (VEC[v].e_hv)
        chk(head_idx_o == VEC[v].e_hidx, $sformatf("R%0d vec%0d head_idx", VEC[v].rq, v),
            head_idx_o, VEC[v].e_hidx);
      chk(pop_freed_o == VEC[v].e_freed, $sformatf("R%0d vec%0d freed", VEC[v].rq, v),
          pop_freed_o, VEC[v].e_freed);
    end

    // R2: stored address and allocation report
    do_reset();
    cmd(3'd1, 3'd0, 16'd0, 3'd1, 16'hABCD);
    chk(alloc_ok_o == 1'b1, "R2 alloc pulse", alloc_ok_o, 1);
    chk(alloc_idx_o == 0, "R2 alloc idx", alloc_idx_o, 0);
    chk(head_addr_o == 16'hABCD, "R2 head addr", head_addr_o, 16'hABCD);
    @(negedge clk);
    chk(alloc_ok_o == 1'b0, "R2 pulse width", alloc_ok_o, 0);

    // R3 / R4: fill across both thresholds (prefetch below 4, full at 7)
    do_reset();
    for (int k = 1; k <= 7; k++) begin
      cmd(3'd1, 3'd0, 16'd0, 3'd1, 16'(k));
      chk(alloc_idx_o == 3'(k - 1), "R2 lowest free", alloc_idx_o, k - 1);
      chk(prefetch_ok_o == (k < 4), "R4 prefetch limit", prefetch_ok_o, k < 4);
      chk(full_o == (k >= 7), "R3 full flag", full_o, k >= 7);
    end
    cmd(3'd1, 3'd0, 16'd0, 3'd1, 16'h0777);
    chk(err_o == 1'b1, "R3 err on full alloc", err_o, 1);
    chk(alloc_ok_o == 1'b0, "R3 no alloc when full", alloc_ok_o, 0);
    chk(used_o == 7, "R3 count held", used_o, 7);
    @(negedge clk);
    chk(err_o == 1'b0, "R3 err pulse width", err_o, 0);

    // R11 then R2: freeing a middle entry makes it the next one taken
    cmd(3'd2, 3'd3, 16'd0, 3'd0, 16'd0);
    chk(used_o == 6 && full_o == 1'b0, "R11 free mid", used_o, 6);
    cmd(3'd2, 3'd3, 16'd0, 3'd0, 16'd0);
    chk(used_o == 6, "R11 free of free entry ignored", used_o, 6);
    cmd(3'd1, 3'd0, 16'd0, 3'd1, 16'h0333);
    chk(alloc_idx_o == 3, "R2 reuse freed slot", alloc_idx_o, 3);

    // R1: reset from a busy state
    do_reset();
    @(negedge clk);
    chk_reset_state("R1 reset after fill");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule